// File: doc/BRIEF.md
# Receive Frame and Multiframe Boundary Generator

This block runs inside the receive side of a T1 or E1 framer. It counts the recovered line bit clock, which arrives as a one-cycle bit enable on the system clock. From that count it produces one-cycle strobes that mark the first bit of each frame and the first bit of each multiframe. It also produces a separate multiframe strobe for the system-bus side, and a phase bit that tells software which half of a two-frame slip buffer may be accessed safely.

The alignment search logic sits outside this block. When that logic finds a frame start, it pulses a resynchronise input. The pulse clears every counter so that the next counted bit is bit 1 of frame 1. The same pulse loads the line-type and framing-format selects, so a change of mode only takes effect at a resync. Frame length is 193 bits for T1 and 256 bits for E1. Multiframe depth and system-bus depth come from the selected framing format. When multiframe alignment is not used on E1, the block keeps a fixed 16-frame interval as a fallback.

Top module: `frame_boundary_gen`

## Requirements
- R1: With `line_sel`=0 (T1) latched, `frame_stb` is high on the first counted bit after reset or resync, and then on every 193rd counted bit.
- R2: With `line_sel`=1 (E1) latched, `frame_stb` is high on every 256th counted bit, starting with the first counted bit.
- R3: `mframe_stb` is high only together with `frame_stb`. It fires on frame 1 and then every 12 frames for `fmt_sel`=00 (SF/SLC), every 24 frames for 01 (ESF), and every 16 frames for 10 (E1 CAS with multiframe alignment).
- R4: With `fmt_sel`=11 (E1 CAS, multiframe alignment not used), `mframe_stb` still fires on frame 1 and then every 16 frames.
- R5: `sysmf_stb` fires on frame 1 and then every 24 frames for `fmt_sel` 00 or 01, and every 16 frames for `fmt_sel` 10 or 11.
- R6: `buf_phase` is 0 after reset and after a resync. It inverts in the cycle after each `frame_stb`.
- R7: A strobe is high only in a cycle where `bit_en` is high, for that one cycle. Cycles with `bit_en` low do not advance any count.
- R8: In a cycle where `resync` is high, no strobe fires and the bit is not counted. The next cycle with `bit_en` high raises all three strobes.
- R9: Changes on `line_sel` and `fmt_sel` are ignored until the next `resync` or reset.
- R10: During reset all strobes are low. Reset loads the selects and clears the counters, so the first counted bit raises all three strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One received line bit in this cycle |
| line_sel | input | 1 | 0 = T1 (193-bit frame), 1 = E1 (256-bit frame) |
| fmt_sel | input | 2 | 00 SF/SLC, 01 ESF, 10 E1 CAS with MF alignment, 11 E1 CAS without |
| resync | input | 1 | Found frame start: clear counters and load selects |
| frame_stb | output | 1 | First bit of a frame |
| mframe_stb | output | 1 | First bit of a receive multiframe |
| sysmf_stb | output | 1 | First bit of a system-bus multiframe |
| buf_phase | output | 1 | Slip-buffer half indicator |

## Verification
A bit counter that is off by one moves `frame_stb` by one bit relative to a count kept from the last resync, and the error shows within one frame (193 or 256 bits). A wrong frame counter or a wrong depth decode misplaces `mframe_stb` or `sysmf_stb` by whole frames, which can take up to 24 frames to appear. For that reason each format is run for at least two system-bus multiframes. A select that leaks through without a resync changes the frame length at once, so the next expected strobe is missed.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    localparam int DEF_T1_BITS      = 193;
    localparam int DEF_E1_BITS      = 256;
    localparam int DEF_SF_FRAMES    = 12;
    localparam int DEF_ESF_FRAMES   = 24;
    localparam int DEF_CAS_FRAMES   = 16;
    localparam int DEF_SB_T1_FRAMES = 24;
    localparam int DEF_SB_CAS_FRAMES = 16;

    typedef enum logic {
        LINE_T1 = 1'b0,
        LINE_E1 = 1'b1
    } line_e;

    typedef enum logic [1:0] {
        FMT_SF        = 2'b00,
        FMT_ESF       = 2'b01,
        FMT_CAS_MAS   = 2'b10,
        FMT_CAS_NOMAS = 2'b11
    } fmt_e;

    typedef struct packed {
        line_e line;
        fmt_e  fmt;
    } mode_t;

    typedef struct packed {
        logic frame;
        logic mframe;
        logic sysmf;
    } strobe_t;

    function automatic int width_for(input int count);
        return (count <= 2) ? 1 : $clog2(count);
    endfunction

    function automatic logic is_cas(input fmt_e f);
        return (f == FMT_CAS_MAS) || (f == FMT_CAS_NOMAS);
    endfunction

    function automatic int mf_frames(input fmt_e f, input int sf_n,
                                     input int esf_n, input int cas_n);
        int r;
        unique case (f)
            FMT_SF:  r = sf_n;
            FMT_ESF: r = esf_n;
            default: r = cas_n;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fbg_mode_latch.sv
module fbg_mode_latch
    import fbg_pkg::*;
#(
    parameter int T1_BITS       = DEF_T1_BITS,
    parameter int E1_BITS       = DEF_E1_BITS,
    parameter int SF_FRAMES     = DEF_SF_FRAMES,
    parameter int ESF_FRAMES    = DEF_ESF_FRAMES,
    parameter int CAS_FRAMES    = DEF_CAS_FRAMES,
    parameter int SB_T1_FRAMES  = DEF_SB_T1_FRAMES,
    parameter int SB_CAS_FRAMES = DEF_SB_CAS_FRAMES,
    parameter int BIT_W         = 9,
    parameter int FRM_W         = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  mode_t            mode_in,
    output mode_t            mode_q,
    output logic [BIT_W-1:0] bit_last,
    output logic [FRM_W-1:0] mf_last,
    output logic [FRM_W-1:0] sb_last
);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            mode_q <= mode_in;
        end
    end

    always_comb begin
        int bl;
        int ml;
        int sl;
        bl = (mode_q.line == LINE_E1) ? (E1_BITS - 1) : (T1_BITS - 1);
        ml = mf_frames(mode_q.fmt, SF_FRAMES, ESF_FRAMES, CAS_FRAMES) - 1;
        sl = is_cas(mode_q.fmt) ? (SB_CAS_FRAMES - 1) : (SB_T1_FRAMES - 1);
        bit_last = BIT_W'(bl);
        mf_last  = FRM_W'(ml);
        sb_last  = FRM_W'(sl);
    end

    // R9: the latched mode moves only on reset or resync
    a_r9_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(mode_q));

endmodule

// File: rtl/fbg_wrap_counter.sv
module fbg_wrap_counter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] last,
    output logic [W-1:0] cnt,
    output logic         at_zero,
    output logic         wrap
);

    assign at_zero = (cnt == '0);
    assign wrap    = adv && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= (cnt == last) ? '0 : cnt + 1'b1;
        end
    end

    // R8: a clear leaves the count at the first position
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    // R7: the count never leaves the range of the latched length
    a_r7_in_range: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt <= last));

    // R7: without advance or clear the count holds
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!adv && !clr) |=> $stable(cnt));

endmodule

// File: rtl/fbg_strobe_gen.sv
module fbg_strobe_gen
    import fbg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bit_en,
    input  logic    resync,
    input  logic    bit_zero,
    input  logic    mf_zero,
    input  logic    sb_zero,
    output strobe_t stb,
    output logic    phase
);

    logic counted;

    assign counted = bit_en && !resync && !rst;

    always_comb begin
        stb.frame  = counted && bit_zero;
        stb.mframe = counted && bit_zero && mf_zero;
        stb.sysmf  = counted && bit_zero && sb_zero;
    end

    always_ff @(posedge clk) begin
        if (rst || resync) begin
            phase <= 1'b0;
        end else if (stb.frame) begin
            phase <= ~phase;
        end
    end

    // R3 and R5: multiframe strobes only on a frame's first bit
    a_r3_mf_in_frame: assert property (@(posedge clk) disable iff (rst)
        stb.mframe |-> stb.frame);
    a_r5_sb_in_frame: assert property (@(posedge clk) disable iff (rst)
        stb.sysmf |-> stb.frame);

    // R7: strobes need a bit enable
    a_r7_only_on_bit: assert property (@(posedge clk) disable iff (rst)
        stb.frame |-> bit_en);

    // R8: nothing fires during a resync
    a_r8_resync_quiet: assert property (@(posedge clk) disable iff (rst)
        resync |-> !(stb.frame || stb.mframe || stb.sysmf));

    // R6: phase flips after a frame strobe and clears after a resync
    a_r6_phase_toggle: assert property (@(posedge clk) disable iff (rst)
        stb.frame |=> (phase != $past(phase)));
    a_r6_phase_clear: assert property (@(posedge clk) disable iff (rst)
        resync |=> !phase);

endmodule

// File: rtl/frame_boundary_gen.sv
module frame_boundary_gen
    import fbg_pkg::*;
#(
    parameter int T1_BITS       = DEF_T1_BITS,
    parameter int E1_BITS       = DEF_E1_BITS,
    parameter int SF_FRAMES     = DEF_SF_FRAMES,
    parameter int ESF_FRAMES    = DEF_ESF_FRAMES,
    parameter int CAS_FRAMES    = DEF_CAS_FRAMES,
    parameter int SB_T1_FRAMES  = DEF_SB_T1_FRAMES,
    parameter int SB_CAS_FRAMES = DEF_SB_CAS_FRAMES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       line_sel,
    input  logic [1:0] fmt_sel,
    input  logic       resync,
    output logic       frame_stb,
    output logic       mframe_stb,
    output logic       sysmf_stb,
    output logic       buf_phase
);

    localparam int MAX_BITS = (T1_BITS > E1_BITS) ? T1_BITS : E1_BITS;
    localparam int MAX_MF0  = (SF_FRAMES > ESF_FRAMES) ? SF_FRAMES : ESF_FRAMES;
    localparam int MAX_MF   = (MAX_MF0 > CAS_FRAMES) ? MAX_MF0 : CAS_FRAMES;
    localparam int MAX_SB   = (SB_T1_FRAMES > SB_CAS_FRAMES) ? SB_T1_FRAMES : SB_CAS_FRAMES;
    localparam int BIT_W    = width_for(MAX_BITS);
    localparam int FRM_W0   = width_for(MAX_MF);
    localparam int FRM_W1   = width_for(MAX_SB);
    localparam int FRM_W    = (FRM_W0 > FRM_W1) ? FRM_W0 : FRM_W1;

    mode_t            mode_in;
    mode_t            mode_q;
    logic [BIT_W-1:0] bit_last;
    logic [FRM_W-1:0] mf_last;
    logic [FRM_W-1:0] sb_last;

    assign mode_in.line = line_e'(line_sel);
    assign mode_in.fmt  = fmt_e'(fmt_sel);

    fbg_mode_latch #(
        .T1_BITS(T1_BITS), .E1_BITS(E1_BITS),
        .SF_FRAMES(SF_FRAMES), .ESF_FRAMES(ESF_FRAMES), .CAS_FRAMES(CAS_FRAMES),
        .SB_T1_FRAMES(SB_T1_FRAMES), .SB_CAS_FRAMES(SB_CAS_FRAMES),
        .BIT_W(BIT_W), .FRM_W(FRM_W)
    ) mode_i (
        .clk(clk), .rst(rst), .load(resync), .mode_in(mode_in),
        .mode_q(mode_q), .bit_last(bit_last), .mf_last(mf_last), .sb_last(sb_last)
    );

    logic             bit_adv;
    logic [BIT_W-1:0] bit_cnt;
    logic             bit_zero;
    logic             bit_wrap;

    assign bit_adv = bit_en && !resync;

    fbg_wrap_counter #(.W(BIT_W)) bit_ctr_i (
        .clk(clk), .rst(rst), .clr(resync), .adv(bit_adv), .last(bit_last),
        .cnt(bit_cnt), .at_zero(bit_zero), .wrap(bit_wrap)
    );

    localparam int NFC = 2;
    logic [FRM_W-1:0] frm_last [NFC];
    logic [FRM_W-1:0] frm_cnt  [NFC];
    logic             frm_zero [NFC];
    logic             frm_wrap [NFC];

    assign frm_last[0] = mf_last;
    assign frm_last[1] = sb_last;

    generate
        for (genvar g = 0; g < NFC; g++) begin : g_frm
            fbg_wrap_counter #(.W(FRM_W)) frm_ctr_i (
                .clk(clk), .rst(rst), .clr(resync), .adv(bit_wrap),
                .last(frm_last[g]), .cnt(frm_cnt[g]),
                .at_zero(frm_zero[g]), .wrap(frm_wrap[g])
            );
        end
    endgenerate

    strobe_t stb;

    fbg_strobe_gen strobe_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .resync(resync),
        .bit_zero(bit_zero), .mf_zero(frm_zero[0]), .sb_zero(frm_zero[1]),
        .stb(stb), .phase(buf_phase)
    );

    assign frame_stb  = stb.frame;
    assign mframe_stb = stb.mframe;
    assign sysmf_stb  = stb.sysmf;

    // R1 and R2: a frame strobe follows the last bit of the previous frame
    a_r1_frame_after_wrap: assert property (@(posedge clk) disable iff (rst || resync)
        bit_wrap |=> (bit_cnt == '0));

    // R10: strobes stay low under reset
    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |-> !(frame_stb || mframe_stb || sysmf_stb));

endmodule

// File: tb/frame_boundary_gen_tb.sv
module frame_boundary_gen_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       line;
        logic [1:0] fmt;
        int         nbits;
        int         fr;
        int         mf;
        int         sb;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'b00, 4632, 24, 2, 1},
        '{1'b0, 2'b01, 9264, 48, 2, 2},
        '{1'b1, 2'b10, 8192, 32, 2, 2},
        '{1'b1, 2'b11, 8192, 32, 2, 2},
        '{1'b0, 2'b00, 2317, 13, 2, 1},
        '{1'b1, 2'b01, 6144, 24, 1, 1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       line_sel = 1'b0;
    logic [1:0] fmt_sel = 2'b00;
    logic       resync = 1'b0;
    logic       frame_stb, mframe_stb, sysmf_stb, buf_phase;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_boundary_gen dut_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .line_sel(line_sel),
        .fmt_sel(fmt_sel), .resync(resync), .frame_stb(frame_stb),
        .mframe_stb(mframe_stb), .sysmf_stb(sysmf_stb), .buf_phase(buf_phase)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference model state
    int  m_len, m_mf, m_sb;
    int  k;
    bit  e_phase;
    int  mism;
    int  cnt_f, cnt_m, cnt_s;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_load(input logic ln, input logic [1:0] fm);
        m_len = ln ? 256 : 193;
        m_mf  = (fm == 2'b00) ? 12 : (fm == 2'b01) ? 24 : 16;
        m_sb  = fm[1] ? 16 : 24;
        k = 0;
        e_phase = 1'b0;
    endtask

    task automatic clear_tally();
        mism = 0; cnt_f = 0; cnt_m = 0; cnt_s = 0;
    endtask

    task automatic tick(input logic en);
        bit ef, em, es;
        int fi;
        @(negedge clk);
        bit_en = en;
        #1;
        fi = k / m_len;
        ef = en && (k % m_len == 0);
        em = ef && (fi % m_mf == 0);
        es = ef && (fi % m_sb == 0);
        if (frame_stb != ef || mframe_stb != em || sysmf_stb != es || buf_phase != e_phase)
            mism++;
        cnt_f += int'(frame_stb);
        cnt_m += int'(mframe_stb);
        cnt_s += int'(sysmf_stb);
        if (en) begin
            if (ef) e_phase = ~e_phase;
            k++;
        end
    endtask

    task automatic do_resync(input logic ln, input logic [1:0] fm, input logic en);
        @(negedge clk);
        line_sel = ln; fmt_sel = fm; resync = 1'b1; bit_en = en;
        #1;
        check(!(frame_stb || mframe_stb || sysmf_stb), "R8 quiet during resync",
              int'(frame_stb) + int'(mframe_stb) + int'(sysmf_stb), 0);
        @(negedge clk);
        resync = 1'b0; bit_en = 1'b0;
        model_load(ln, fm);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R10: reset with bit enable active, strobes stay low
        bit_en = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(!(frame_stb || mframe_stb || sysmf_stb), "R10 strobes low in reset",
              int'(frame_stb) + int'(mframe_stb) + int'(sysmf_stb), 0);
        @(negedge clk);
        rst = 1'b0; bit_en = 1'b0;
        #1;
        check(buf_phase == 1'b0, "R6 phase after reset", int'(buf_phase), 0);
        model_load(1'b0, 2'b00);
        clear_tally();
        tick(1'b1);
        check(frame_stb && mframe_stb && sysmf_stb, "R10 first bit raises all strobes",
              int'(frame_stb) + int'(mframe_stb) + int'(sysmf_stb), 3);
        @(negedge clk); #1;
        check(buf_phase == 1'b1, "R6 phase toggles after frame strobe", int'(buf_phase), 1);

        // table walk: R1 R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            do_resync(VECS[v].line, VECS[v].fmt, 1'b0);
            clear_tally();
            for (int b = 0; b < VECS[v].nbits; b++) tick(1'b1);
            check(mism == 0, "R1 R2 R3 R4 R5 R6 per-bit strobe and phase", mism, 0);
            check(cnt_f == VECS[v].fr, "R1 R2 frame count", cnt_f, VECS[v].fr);
            check(cnt_m == VECS[v].mf, "R3 R4 multiframe count", cnt_m, VECS[v].mf);
            check(cnt_s == VECS[v].sb, "R5 system-bus count", cnt_s, VECS[v].sb);
        end

        // R7: idle cycles between bits neither strobe nor count
        do_resync(1'b1, 2'b10, 1'b0);
        clear_tally();
        for (int b = 0; b < 600; b++) begin
            tick(1'b1);
            tick(1'b0);
            if (b % 3 == 0) tick(1'b0);
        end
        check(mism == 0, "R7 gaps between bits", mism, 0);
        check(cnt_f == 3, "R7 frame count with gaps", cnt_f, 3);

        // R9: selects changed without resync are ignored
        do_resync(1'b0, 2'b00, 1'b0);
        clear_tally();
        @(negedge clk);
        line_sel = 1'b1; fmt_sel = 2'b11;
        for (int b = 0; b < 400; b++) tick(1'b1);
        check(mism == 0, "R9 mode held without resync", mism, 0);
        check(cnt_f == 3, "R9 T1 frame count kept", cnt_f, 3);

        // R8: resync mid-frame, coinciding with a bit
        do_resync(1'b1, 2'b01, 1'b0);
        clear_tally();
        for (int b = 0; b < 77; b++) tick(1'b1);
        check(buf_phase == 1'b1, "R6 phase before resync", int'(buf_phase), 1);
        do_resync(1'b1, 2'b01, 1'b1);
        #1;
        check(buf_phase == 1'b0, "R6 phase cleared by resync", int'(buf_phase), 0);
        clear_tally();
        tick(1'b1);
        check(frame_stb && mframe_stb && sysmf_stb, "R8 next bit is frame 1 bit 1",
              int'(frame_stb) + int'(mframe_stb) + int'(sysmf_stb), 3);
        for (int b = 0; b < 600; b++) tick(1'b1);
        check(mism == 0, "R8 R2 counting after resync", mism, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule